// File: doc/BRIEF.md
# Sleep-Time Interrupt Recorder with Replay

This block sits beside a group of external interrupt lines while the interrupt controller that normally serves them is powered down. Every line passes through a two-flop synchronizer and a per-line trigger detector (rising edge, falling edge, active-high level or active-low level, chosen by a sensitivity bit and a polarity bit). Any detected event on an unmasked line sets a sticky status bit. This happens whether or not the block is enabled, so software must acknowledge stale bits before it arms the block for sleep.

After wake-up, software writes a flush command. A small sequencer then walks the status words one per cycle, starting at word 0. For each line that is latched and unmasked it emits a one-cycle pulse on the output vector toward the parent controller, and it clears that status bit. A busy flag, visible in the control word and on a port, stays high for the length of the walk.

Configuration uses a 32-bit register interface. Mask, sensitivity and polarity each have a write-one-to-set bank and a write-one-to-clear bank. Status has a read bank and a write-one-to-acknowledge bank. A single control word holds the enable, edge-only and flush bits.

Top module: `sleep_irq_recorder`

## Requirements
- R1: After reset, status reads 0 and mask reads all ones (every line masked). Sensitivity, polarity and the control word read 0, and the replay output and busy are 0.
- R2: Line n lives at bit n mod 32 of the word at bank base + 4*(n/32). The bank bases are: status 0x000, acknowledge 0x040, mask set 0x0C0, mask clear 0x100, sensitivity set 0x180, sensitivity clear 0x1C0, polarity set 0x240, polarity clear 0x280, control 0x300. Writing 1 to a bit of a set or clear bank sets or clears that line's bit, and writing 0 leaves it unchanged. Both the set address and the clear address of a bank read back the current value.
- R3: With sensitivity 0 (edge), polarity 1 latches on a rising edge and polarity 0 latches on a falling edge. A change driven between clock edges shows in status after the third following rising clock edge and not after the second. An edge of the opposite direction is not latched.
- R4: With sensitivity 1 (level), polarity 1 latches while the line is high and polarity 0 latches while it is low. The latch repeats every cycle, so an acknowledge issued while the level persists leaves the bit set.
- R5: A line whose mask bit is 1 never latches status.
- R6: Events latch whether the enable bit (control bit 0) is 0 or 1.
- R7: With edge-only mode (control bit 1) set, level-configured lines do not latch, while edge-configured lines still do.
- R8: Writing 1 to a bit in the acknowledge bank clears that line's status. A new event in the same cycle wins over the clear.
- R9: Writing the control word with bit 2 and bit 0 both set starts a replay. The cycle after the write, word 0 drives a one-cycle pulse on every latched, unmasked line in it. Each later word follows one cycle after the one before. Busy (read as control bit 2 and on replay_busy) is high for exactly one cycle per status word. Every replayed status bit is cleared.
- R10: A flush written with control bit 0 at 0, or written while busy, starts no replay and does not change status.
- R11: A latched line that is masked at replay time gets no pulse and keeps its status bit.
- R12: Control bits 0 and 1 read back as written. Writes to unaligned addresses, to undefined offsets, or to words past the last line have no effect, and such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | NUM_LINES | Replay pulses toward the parent controller |
| replay_busy | output | 1 | High while a replay walk is in progress |

## Verification
The bench targets the latency of the synchronizer and detector, so a design with one flop too few or too many reports the latch a cycle early or late. It drives edges in the wrong direction for a line's polarity, where a detector that ignores polarity latches anyway. It sends an acknowledge while a level is still asserted, where a clear-priority design loses the event. It checks replay word by word, so a sequencer that skips a word, pulses a masked line, or clears a masked line's status shows a wrong output or a wrong status word. It also re-issues flush while busy and with enable low, where a design that accepts either stays busy too long or pulses when it must not.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int WORD_BITS = 32;
    localparam int ADDR_W    = 12;

    // Register banks, selected by address bits [11:6]
    typedef enum logic [5:0] {
        BK_STATUS = 6'h00,
        BK_ACK    = 6'h01,
        BK_MSET   = 6'h03,
        BK_MCLR   = 6'h04,
        BK_SSET   = 6'h06,
        BK_SCLR   = 6'h07,
        BK_PSET   = 6'h09,
        BK_PCLR   = 6'h0A,
        BK_CTRL   = 6'h0C
    } bank_e;

    // Control word bit positions
    localparam int CB_EN    = 0;
    localparam int CB_EDGE  = 1;
    localparam int CB_FLUSH = 2;

    typedef struct packed {
        logic edge_only;
        logic enable;
    } ctrl_t;

    function automatic int word_count(input int lines);
        return (lines + WORD_BITS - 1) / WORD_BITS;
    endfunction

    function automatic int index_width(input int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction

endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int N  = 64,
    parameter int NW = word_count(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N-1:0]      status,
    input  logic              busy,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      sense,
    output logic [N-1:0]      pol,
    output ctrl_t             ctrl,
    output logic [N-1:0]      ack_vec,
    output logic              flush_go
);

    bank_e      bank;
    logic [3:0] word;
    logic       aligned;
    logic       wr_hit;

    assign bank    = bank_e'(bus_addr[11:6]);
    assign word    = bus_addr[5:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_wr && aligned;

    // Configuration banks: write-one-to-set / write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '1;
            sense <= '0;
            pol   <= '0;
        end else if (wr_hit) begin
            for (int i = 0; i < N; i++) begin
                if (word == 4'(i / WORD_BITS) && bus_wdata[i % WORD_BITS]) begin
                    case (bank)
                        BK_MSET: mask[i]  <= 1'b1;
                        BK_MCLR: mask[i]  <= 1'b0;
                        BK_SSET: sense[i] <= 1'b1;
                        BK_SCLR: sense[i] <= 1'b0;
                        BK_PSET: pol[i]   <= 1'b1;
                        BK_PCLR: pol[i]   <= 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Control word
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_hit && bank == BK_CTRL && word == 4'd0) begin
            ctrl.enable    <= bus_wdata[CB_EN];
            ctrl.edge_only <= bus_wdata[CB_EDGE];
        end
    end

    // Flush only with enable in the same write and no walk in progress
    assign flush_go = wr_hit && bank == BK_CTRL && word == 4'd0 &&
                      bus_wdata[CB_FLUSH] && bus_wdata[CB_EN] && !busy;

    always_comb begin
        ack_vec = '0;
        for (int i = 0; i < N; i++) begin
            ack_vec[i] = wr_hit && bank == BK_ACK &&
                         word == 4'(i / WORD_BITS) && bus_wdata[i % WORD_BITS];
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (bank == BK_CTRL && word == 4'd0) begin
                bus_rdata[CB_EN]    = ctrl.enable;
                bus_rdata[CB_EDGE]  = ctrl.edge_only;
                bus_rdata[CB_FLUSH] = busy;
            end else begin
                for (int i = 0; i < N; i++) begin
                    if (word == 4'(i / WORD_BITS)) begin
                        case (bank)
                            BK_STATUS:        bus_rdata[i % WORD_BITS] = status[i];
                            BK_MSET, BK_MCLR: bus_rdata[i % WORD_BITS] = mask[i];
                            BK_SSET, BK_SCLR: bus_rdata[i % WORD_BITS] = sense[i];
                            BK_PSET, BK_PCLR: bus_rdata[i % WORD_BITS] = pol[i];
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // R2: a set write to line 0's mask bit takes effect on the next cycle
    a_r2_mask_set: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && bank == BK_MSET && word == 4'd0 && bus_wdata[0]) |=> mask[0]);

    // R2: a clear write to line 0's polarity bit takes effect on the next cycle
    a_r2_pol_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && bank == BK_PCLR && word == 4'd0 && bus_wdata[0]) |=> !pol[0]);

endmodule

// File: rtl/sirq_detect.sv
module sirq_detect
    import sirq_pkg::*;
#(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines_in,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] pol,
    input  logic         edge_only,
    output logic [N-1:0] event_vec
);

    logic [N-1:0] sync1, sync2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= lines_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise, fall, edge_hit, level_hit;
        assign rise      = sync2[g] & ~prev[g];
        assign fall      = ~sync2[g] & prev[g];
        assign edge_hit  = pol[g] ? rise : fall;
        assign level_hit = (pol[g] ? sync2[g] : ~sync2[g]) & ~edge_only;
        assign event_vec[g] = ~mask[g] & (sense[g] ? level_hit : edge_hit);
    end

    // R3: an edge-mode line with no change in the synchronized value raises no event
    a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
        ((sense[0] == 1'b0) && (sync2[0] == prev[0])) |-> !event_vec[0]);

endmodule

// File: rtl/sirq_replay.sv
module sirq_replay
    import sirq_pkg::*;
#(
    parameter int N  = 64,
    parameter int NW = word_count(N),
    parameter int IW = index_width(NW)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] event_vec,
    input  logic [N-1:0] ack_vec,
    input  logic [N-1:0] mask,
    input  logic         flush_go,
    output logic [N-1:0] status,
    output logic [N-1:0] irq_out,
    output logic         busy
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);

    logic [IW-1:0] idx;
    logic [N-1:0]  pulse;

    always_comb begin
        pulse = '0;
        for (int i = 0; i < N; i++) begin
            pulse[i] = busy && (idx == IW'(i / WORD_BITS)) && status[i] && !mask[i];
        end
    end

    assign irq_out = pulse;

    // Set wins over replay clear and acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~pulse & ~ack_vec) | event_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (flush_go) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST_IDX) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R9: every replayed line leaves status cleared unless a new event arrived
    a_r9_replay_clears: assert property (@(posedge clk) disable iff (rst)
        (|irq_out) |=> ((status & $past(irq_out) & ~$past(event_vec)) == '0));

    // R11: a masked line never pulses
    a_r11_masked_silent: assert property (@(posedge clk) disable iff (rst)
        ((irq_out & mask) == '0));

    // R6: a status bit only rises when an event was present
    a_r6_latch_cause: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(event_vec)) == '0));

endmodule

// File: rtl/sleep_irq_recorder.sv
module sleep_irq_recorder
    import sirq_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_out,
    output logic                 replay_busy
);

    localparam int NW = word_count(NUM_LINES);

    logic [NUM_LINES-1:0] mask, sense, pol, ack_vec, status, event_vec;
    ctrl_t                ctrl;
    logic                 flush_go;

    sirq_regs #(.N(NUM_LINES), .NW(NW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status    (status),
        .busy      (replay_busy),
        .mask      (mask),
        .sense     (sense),
        .pol       (pol),
        .ctrl      (ctrl),
        .ack_vec   (ack_vec),
        .flush_go  (flush_go)
    );

    sirq_detect #(.N(NUM_LINES)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .lines_in  (irq_lines),
        .mask      (mask),
        .sense     (sense),
        .pol       (pol),
        .edge_only (ctrl.edge_only),
        .event_vec (event_vec)
    );

    sirq_replay #(.N(NUM_LINES), .NW(NW)) u_replay (
        .clk       (clk),
        .rst       (rst),
        .event_vec (event_vec),
        .ack_vec   (ack_vec),
        .mask      (mask),
        .flush_go  (flush_go),
        .status    (status),
        .irq_out   (irq_out),
        .busy      (replay_busy)
    );

    // R10: a replay only starts when the enable bit is set
    a_r10_start_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(replay_busy) |-> ctrl.enable);

    // R5: a masked line never produces an event
    a_r5_masked_no_event: assert property (@(posedge clk) disable iff (rst)
        ((event_vec & mask) == '0));

endmodule

// File: tb/sim_sleep_irq_recorder.sv
`timescale 1ns/1ps
module sim_sleep_irq_recorder;

    localparam int NL = 64;
    localparam logic [11:0] A_STAT = 12'h000, A_ACK = 12'h040, A_MSET = 12'h0C0,
                            A_MCLR = 12'h100, A_SSET = 12'h180, A_SCLR = 12'h1C0,
                            A_PSET = 12'h240, A_PCLR = 12'h280, A_CTRL = 12'h300;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] irq_lines = '0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_out;
    logic          replay_busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sleep_irq_recorder #(.NUM_LINES(NL)) u0 (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .replay_busy(replay_busy)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, {32'h0, v}, {32'h0, exp});
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check("R1 status w0", A_STAT, 32'h0);
        rd_check("R1 status w1", A_STAT + 12'h4, 32'h0);
        rd_check("R1 mask w1", A_MSET + 12'h4, 32'hFFFF_FFFF);
        rd_check("R1 sense w0", A_SSET, 32'h0);
        rd_check("R1 ctrl", A_CTRL, 32'h0);
        check("R1 irq_out", irq_out, 64'h0);
        check("R1 busy", {63'h0, replay_busy}, 64'h0);
    endtask

    task automatic t_banks();
        wr(A_MCLR + 12'h4, 32'h20);                       // line 37
        rd_check("R2 mask clear line37", A_MSET + 12'h4, 32'hFFFF_FFDF);
        wr(A_MCLR + 12'h4, 32'h0);
        rd_check("R2 zero write no effect", A_MCLR + 12'h4, 32'hFFFF_FFDF);
        wr(A_MSET + 12'h4, 32'h20);
        rd_check("R2 mask set line37", A_MSET + 12'h4, 32'hFFFF_FFFF);
        wr(A_PSET, 32'hF0);
        rd_check("R2 pol readback at clear addr", A_PCLR, 32'hF0);
        wr(A_PCLR, 32'h30);
        rd_check("R2 pol clear", A_PSET, 32'hC0);
        wr(A_PCLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(A_PSET, 32'h8);                                // line 3 rising
        wr(A_MCLR, 32'h8);
        @(negedge clk); irq_lines[3] = 1'b1;
        cycles(2); rd(A_STAT, v);
        check("R3 not latched after two edges", {32'h0, v}, 64'h0);
        cycles(1); rd(A_STAT, v);
        check("R3 rising latched after third edge", {32'h0, v}, 64'h8);
        wr(A_ACK, 32'h8);
        rd_check("R8 ack clears", A_STAT, 32'h0);
        wr(A_MCLR + 12'h4, 32'h100);                      // line 40 falling
        @(negedge clk); irq_lines[40] = 1'b1;
        cycles(4);
        rd_check("R3 rising ignored on falling line", A_STAT + 12'h4, 32'h0);
        irq_lines[40] = 1'b0;
        cycles(4);
        rd_check("R3 falling latched", A_STAT + 12'h4, 32'h100);
        wr(A_ACK + 12'h4, 32'h100);
        irq_lines[3] = 1'b0;
        cycles(4);
        rd_check("R3 falling ignored on rising line", A_STAT, 32'h0);
    endtask

    task automatic t_level();
        wr(A_SSET, 32'h400);                              // line 10 high level
        wr(A_PSET, 32'h400);
        wr(A_MCLR, 32'h400);
        cycles(4);
        rd_check("R4 no latch while inactive", A_STAT, 32'h0);
        irq_lines[10] = 1'b1;
        cycles(4);
        rd_check("R4 level high latched", A_STAT, 32'h400);
        wr(A_ACK, 32'h400);
        rd_check("R8 set wins while level held", A_STAT, 32'h400);
        irq_lines[10] = 1'b0;
        cycles(4);
        wr(A_ACK, 32'h400);
        cycles(1);
        rd_check("R4 clear after release", A_STAT, 32'h0);
        wr(A_SSET, 32'h800);                              // line 11 low level
        wr(A_MCLR, 32'h800);
        cycles(2);
        rd_check("R4 level low latched", A_STAT, 32'h800);
        irq_lines[11] = 1'b1;
        cycles(4);
        wr(A_ACK, 32'h800);
        cycles(1);
        rd_check("R4 level low released", A_STAT, 32'h0);
    endtask

    task automatic t_mask();
        wr(A_PSET, 32'h0010_0000);                        // line 20, still masked
        irq_lines[20] = 1'b1;
        cycles(4);
        irq_lines[20] = 1'b0;
        cycles(4);
        rd_check("R5 masked line not latched", A_STAT, 32'h0);
    endtask

    task automatic t_edge_only();
        wr(A_CTRL, 32'h2);                                // edge-only, disabled
        rd_check("R12 ctrl readback", A_CTRL, 32'h2);
        irq_lines[10] = 1'b1;
        irq_lines[3]  = 1'b1;
        cycles(4);
        rd_check("R7 R6 level blocked, edge latched while disabled", A_STAT, 32'h8);
        irq_lines[10] = 1'b0;
        cycles(4);
    endtask

    task automatic t_flush_disabled();
        wr(A_CTRL, 32'h6);
        check("R10 no pulse when disabled", irq_out, 64'h0);
        check("R10 not busy when disabled", {63'h0, replay_busy}, 64'h0);
        rd_check("R10 status kept", A_STAT, 32'h8);
    endtask

    task automatic t_replay();
        logic [31:0] v;
        irq_lines[40] = 1'b1; cycles(4);
        irq_lines[40] = 1'b0; cycles(4);
        wr(A_MCLR, 32'h0010_0000);
        irq_lines[20] = 1'b1; cycles(4);
        wr(A_MSET, 32'h0010_0000);
        rd_check("R9 pre-replay status w0", A_STAT, 32'h0010_0008);
        wr(A_CTRL, 32'h7);
        check("R9 R11 word0 pulse", irq_out, 64'h8);
        rd(A_CTRL, v);
        check("R9 busy in ctrl", {32'h0, v}, 64'h7);
        @(negedge clk);
        check("R9 word1 pulse", irq_out, 64'h1 << 40);
        @(negedge clk);
        check("R9 quiet after walk", irq_out, 64'h0);
        check("R9 busy dropped", {63'h0, replay_busy}, 64'h0);
        rd_check("R9 ctrl after walk", A_CTRL, 32'h3);
        rd_check("R11 masked line kept", A_STAT, 32'h0010_0000);
        rd_check("R9 word1 cleared", A_STAT + 12'h4, 32'h0);
    endtask

    task automatic t_flush_busy();
        irq_lines[3] = 1'b0; cycles(4);
        irq_lines[3] = 1'b1; cycles(4);
        wr(A_CTRL, 32'h7);
        check("R9 second walk word0", irq_out, 64'h8);
        bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h7;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        @(negedge clk);
        check("R10 flush while busy ignored", {63'h0, replay_busy}, 64'h0);
        check("R10 no extra pulse", irq_out, 64'h0);
        rd_check("R10 status after busy flush", A_STAT, 32'h0010_0000);
    endtask

    task automatic t_undefined();
        wr(12'h3FC, 32'hFFFF_FFFF);
        rd_check("R12 undefined offset reads 0", 12'h3FC, 32'h0);
        wr(A_MSET + 12'h8, 32'hFFFF_FFFF);
        rd_check("R12 word past last line reads 0", A_MSET + 12'h8, 32'h0);
        wr(A_MCLR + 12'h1, 32'hFFFF_FFFF);
        rd_check("R12 unaligned write ignored", A_MSET, 32'hFFFF_F3F7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_banks();
        t_edge();
        t_level();
        t_mask();
        t_edge_only();
        t_flush_disabled();
        t_replay();
        t_flush_busy();
        t_undefined();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule